// File: doc/BRIEF.md
# Shifted Masked Bitplane Compositor

This block draws a masked image into a bitplane frame buffer one 32-bit word at a time. For every destination word it fetches a mask word and a source word and shifts both right by a pixel offset. The bits pushed out of one word are carried into the top of the next word of the same row. The shifted mask then selects which destination bits are replaced by shifted source bits. Each row gets one extra trailing destination word, which takes the bits still held in the carries. Rows are repeated for a line count, and the whole row set is repeated for each bitplane. Every plane shares the same mask.

Software loads base addresses, byte strides, the width in words, the row count, the plane count and the shift, and then pulses `start`. The block drives a simple synchronous memory port on its own. Read data is returned one cycle after the read strobe. `done` pulses once the last write has gone out.

A second mode is meant for objects one word wide. In this mode the block fetches and shifts the mask once per row and keeps it, then walks every plane of that row before moving on. This saves one memory read per plane.

Top module: `masked_blit`

## Requirements
- R1: For each destination word the block issues a mask read, a source read and a destination read, in that order, followed by one write to the same destination address. Read data is taken from `memRdata` in the cycle after the read strobe. `memRd` and `memWr` are never high together.
- R2: Each mask and source word w is shifted right by n = `shiftAmt` (0..31). The value used is (w >> n) | (previous word of the row << (32-n)). When n = 0 nothing is carried.
- R3: The written value is computed bitwise as (destination AND NOT shifted mask) OR shifted source.
- R4: After the last word of each row, the block reads and writes one more destination word at row address + 4·`widthWords`. This word is combined using only the leftover mask and source carries, and it causes no mask or source read.
- R5: The carries start at zero on every row. In reuse mode the source carry restarts on every plane, while the row's mask and mask carry are kept for all planes of that row.
- R6: In the default mode the order is planes outer, rows middle and words inner. Byte addresses are: source = `srcBase` + p·`srcPlaneStride` + r·`srcStride` + 4w; destination = `dstBase` + p·`dstPlaneStride` + r·`dstStride` + 4w; mask = `maskBase` + r·`maskStride` + 4w. Every access address is a multiple of 4.
- R7: With `reuseMask` = 1 the order is rows outer and planes inner. The mask is read only once per row, so each row costs 1 + 3·planes reads and 2·planes writes.
- R8: If `reuseMask` = 1 and `widthWords` is not 1, `err` is raised and no memory access is made.
- R9: If any base or stride input has a nonzero value in bits [1:0], `err` is raised, no memory access is made and `done` stays low.
- R10: `done` is high for exactly one cycle, the cycle after the final write. If `widthWords`, `lineCount` or `planeCount` is zero, `done` still pulses and no memory access is made.
- R11: `err` stays set until the next `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, sampled while idle |
| reuseMask | input | 1 | 1 = hold each row's mask across planes |
| shiftAmt | input | 5 | Right shift in bits |
| widthWords | input | 5 | Object width in 32-bit words |
| lineCount | input | 6 | Rows per plane |
| planeCount | input | 3 | Number of bitplanes |
| srcBase | input | 12 | Source byte address |
| maskBase | input | 12 | Mask byte address |
| dstBase | input | 12 | Destination byte address |
| srcStride | input | 12 | Source row pitch, bytes |
| maskStride | input | 12 | Mask row pitch, bytes |
| dstStride | input | 12 | Destination row pitch, bytes |
| srcPlaneStride | input | 12 | Source plane pitch, bytes |
| dstPlaneStride | input | 12 | Destination plane pitch, bytes |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memAddr | output | 12 | Byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, one cycle after `memRd` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky configuration error |

## Verification
The bench goes after the shift extremes 0, 5, 17 and 31. A design that dropped or misplaced the carry would corrupt the top bits of every word after the first, and one that shifted by 32 for n = 0 would smear data into the trailing word. Access traces are compared address by address, which catches a missing trailing word, a mask fetched once per plane in reuse mode, or a row/plane nesting swapped between the two modes. The error paths are also exercised: a misaligned base and reuse mode with a wide object must leave memory untouched, and a later valid start must clear the flag. A zero-row job must still produce `done`.

// File: rtl/masked_blit_pkg.sv
package masked_blit_pkg;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic latchMask;   // capture shifted mask from memRdata
    logic latchSrc;    // capture shifted source from memRdata
    logic useTail;     // trailing word: combine carries only
    logic clrMaskRem;  // zero mask carry
    logic clrSrcRem;   // zero source carry
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MRD,
    ST_SRD,
    ST_DRD,
    ST_WRT,
    ST_FIN
  } blitState_t;

endpackage

// File: rtl/masked_blit_dp.sv
module masked_blit_dp
  import masked_blit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0]   maskCur, maskRem, srcCur, srcRem;
  logic [2*DATA_W-1:0] spread;
  logic [DATA_W-1:0]   maskSel, srcSel;

  // upper half: shifted word, lower half: bits pushed out
  assign spread = {rdData, {DATA_W{1'b0}}} >> shiftAmt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskCur <= '0;
      maskRem <= '0;
      srcCur  <= '0;
      srcRem  <= '0;
    end else begin
      if (ctl.latchMask) begin
        maskCur <= spread[2*DATA_W-1:DATA_W] | maskRem;
        maskRem <= spread[DATA_W-1:0];
      end else if (ctl.clrMaskRem) begin
        maskRem <= '0;
      end
      if (ctl.latchSrc) begin
        srcCur <= spread[2*DATA_W-1:DATA_W] | srcRem;
        srcRem <= spread[DATA_W-1:0];
      end else if (ctl.clrSrcRem) begin
        srcRem <= '0;
      end
    end
  end

  always_comb begin
    maskSel = ctl.useTail ? maskRem : maskCur;
    srcSel  = ctl.useTail ? srcRem  : srcCur;
    wrData  = (rdData & ~maskSel) | srcSel;
  end

endmodule

// File: rtl/masked_blit_ctrl.sv
module masked_blit_ctrl
  import masked_blit_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WCNT_W = 5,
  parameter int LCNT_W = 6,
  parameter int PCNT_W = 3,
  parameter int SH_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              reuseMask,
  input  logic [SH_W-1:0]   shiftIn,
  input  logic [WCNT_W-1:0] widthWords,
  input  logic [LCNT_W-1:0] lineCount,
  input  logic [PCNT_W-1:0] planeCount,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] maskBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [ADDR_W-1:0] srcStride,
  input  logic [ADDR_W-1:0] maskStride,
  input  logic [ADDR_W-1:0] dstStride,
  input  logic [ADDR_W-1:0] srcPlaneStride,
  input  logic [ADDR_W-1:0] dstPlaneStride,
  output dpCtl_t            ctl,
  output logic [SH_W-1:0]   shiftOut,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              done,
  output logic              err
);

  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

  blitState_t        state;
  logic              reuseR, fromMask, errFlag;
  logic [WCNT_W-1:0] widthR, wordIdx;
  logic [LCNT_W-1:0] linesR, lineIdx;
  logic [PCNT_W-1:0] planesR, planeIdx;
  logic [ADDR_W-1:0] sStrR, mStrR, dStrR, sPlStrR, dPlStrR, maskBaseR;
  logic [ADDR_W-1:0] sOuter, dOuter, sRow, dRow, mRow, wOff;
  logic [SH_W-1:0]   shiftR;

  logic tail, lastLine, lastPlane, nextIsTail, misaligned, badReuse, emptyJob;

  always_comb begin
    tail       = (wordIdx == widthR);
    lastLine   = (lineIdx == linesR - LCNT_W'(1));
    lastPlane  = (planeIdx == planesR - PCNT_W'(1));
    nextIsTail = (wordIdx + WCNT_W'(1)) == widthR;
    misaligned = |{srcBase[1:0], maskBase[1:0], dstBase[1:0], srcStride[1:0],
                   maskStride[1:0], dstStride[1:0], srcPlaneStride[1:0],
                   dstPlaneStride[1:0]};
    badReuse   = reuseMask && (widthWords != WCNT_W'(1));
    emptyJob   = (widthWords == '0) || (lineCount == '0) || (planeCount == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      reuseR    <= 1'b0;
      fromMask  <= 1'b0;
      errFlag   <= 1'b0;
      widthR    <= '0;
      wordIdx   <= '0;
      linesR    <= '0;
      lineIdx   <= '0;
      planesR   <= '0;
      planeIdx  <= '0;
      sStrR     <= '0;
      mStrR     <= '0;
      dStrR     <= '0;
      sPlStrR   <= '0;
      dPlStrR   <= '0;
      maskBaseR <= '0;
      sOuter    <= '0;
      dOuter    <= '0;
      sRow      <= '0;
      dRow      <= '0;
      mRow      <= '0;
      wOff      <= '0;
      shiftR    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          errFlag   <= misaligned || badReuse;
          reuseR    <= reuseMask;
          widthR    <= widthWords;
          linesR    <= lineCount;
          planesR   <= planeCount;
          sStrR     <= srcStride;
          mStrR     <= maskStride;
          dStrR     <= dstStride;
          sPlStrR   <= srcPlaneStride;
          dPlStrR   <= dstPlaneStride;
          maskBaseR <= maskBase;
          shiftR    <= shiftIn;
          sOuter    <= srcBase;
          dOuter    <= dstBase;
          sRow      <= srcBase;
          dRow      <= dstBase;
          mRow      <= maskBase;
          wOff      <= '0;
          wordIdx   <= '0;
          lineIdx   <= '0;
          planeIdx  <= '0;
          if (!(misaligned || badReuse)) state <= emptyJob ? ST_FIN : ST_MRD;
        end
        ST_MRD: begin
          fromMask <= 1'b1;
          state    <= ST_SRD;
        end
        ST_SRD: begin
          fromMask <= 1'b0;
          state    <= ST_DRD;
        end
        ST_DRD: state <= ST_WRT;
        ST_WRT: begin
          if (!tail) begin
            wordIdx <= wordIdx + WCNT_W'(1);
            wOff    <= wOff + WORD_BYTES;
            state   <= nextIsTail ? ST_DRD : ST_MRD;
          end else begin
            wordIdx <= '0;
            wOff    <= '0;
            if (!reuseR) begin
              if (!lastLine) begin
                lineIdx <= lineIdx + LCNT_W'(1);
                sRow    <= sRow + sStrR;
                dRow    <= dRow + dStrR;
                mRow    <= mRow + mStrR;
                state   <= ST_MRD;
              end else if (!lastPlane) begin
                planeIdx <= planeIdx + PCNT_W'(1);
                lineIdx  <= '0;
                sOuter   <= sOuter + sPlStrR;
                dOuter   <= dOuter + dPlStrR;
                sRow     <= sOuter + sPlStrR;
                dRow     <= dOuter + dPlStrR;
                mRow     <= maskBaseR;
                state    <= ST_MRD;
              end else begin
                state <= ST_FIN;
              end
            end else begin
              if (!lastPlane) begin
                planeIdx <= planeIdx + PCNT_W'(1);
                sRow     <= sRow + sPlStrR;
                dRow     <= dRow + dPlStrR;
                state    <= ST_SRD;
              end else if (!lastLine) begin
                lineIdx  <= lineIdx + LCNT_W'(1);
                planeIdx <= '0;
                sOuter   <= sOuter + sStrR;
                dOuter   <= dOuter + dStrR;
                sRow     <= sOuter + sStrR;
                dRow     <= dOuter + dStrR;
                mRow     <= mRow + mStrR;
                state    <= ST_MRD;
              end else begin
                state <= ST_FIN;
              end
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.latchMask  = (state == ST_SRD) && fromMask;
    ctl.latchSrc   = (state == ST_DRD) && !tail;
    ctl.useTail    = tail;
    ctl.clrSrcRem  = ((state == ST_IDLE) && start) || ((state == ST_WRT) && tail);
    ctl.clrMaskRem = ((state == ST_IDLE) && start) ||
                     ((state == ST_WRT) && tail && (!reuseR || lastPlane));
    memRd    = (state == ST_MRD) || (state == ST_SRD) || (state == ST_DRD);
    memWr    = (state == ST_WRT);
    case (state)
      ST_MRD:  memAddr = mRow + wOff;
      ST_SRD:  memAddr = sRow + wOff;
      default: memAddr = dRow + wOff;
    endcase
    done     = (state == ST_FIN);
    err      = errFlag;
    shiftOut = shiftR;
  end

endmodule

// File: rtl/masked_blit.sv
module masked_blit
  import masked_blit_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WCNT_W = 5,
  parameter int LCNT_W = 6,
  parameter int PCNT_W = 3,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              reuseMask,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic [WCNT_W-1:0] widthWords,
  input  logic [LCNT_W-1:0] lineCount,
  input  logic [PCNT_W-1:0] planeCount,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] maskBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [ADDR_W-1:0] srcStride,
  input  logic [ADDR_W-1:0] maskStride,
  input  logic [ADDR_W-1:0] dstStride,
  input  logic [ADDR_W-1:0] srcPlaneStride,
  input  logic [ADDR_W-1:0] dstPlaneStride,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done,
  output logic              err
);

  dpCtl_t          ctl;
  logic [SH_W-1:0] shiftR;

  masked_blit_ctrl #(
    .ADDR_W(ADDR_W), .WCNT_W(WCNT_W), .LCNT_W(LCNT_W),
    .PCNT_W(PCNT_W), .SH_W(SH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reuseMask(reuseMask),
    .shiftIn(shiftAmt), .widthWords(widthWords), .lineCount(lineCount),
    .planeCount(planeCount), .srcBase(srcBase), .maskBase(maskBase),
    .dstBase(dstBase), .srcStride(srcStride), .maskStride(maskStride),
    .dstStride(dstStride), .srcPlaneStride(srcPlaneStride),
    .dstPlaneStride(dstPlaneStride), .ctl(ctl), .shiftOut(shiftR),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .done(done), .err(err)
  );

  masked_blit_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shiftAmt(shiftR),
    .rdData(memRdata), .wrData(memWdata)
  );

endmodule

// File: rtl/masked_blit_chk.sv
module masked_blit_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRd,
  input logic              memWr,
  input logic [ADDR_W-1:0] memAddr,
  input logic              done,
  input logic              err
);

  // R1: one port access per cycle
  p_single_access_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R1: every write is preceded by a destination read
  p_write_after_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(memRd));

  // R6: addresses stay word aligned
  p_aligned_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> (memAddr[1:0] == 2'b00));

  // R9: a flagged job neither writes nor completes
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!memWr && !done));

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: no access while signalling completion
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memRd && !memWr));

endmodule

bind masked_blit masked_blit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memRd(memRd), .memWr(memWr),
  .memAddr(memAddr), .done(done), .err(err)
);

// File: tb/sim_masked_blit.sv
module sim_masked_blit;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int MEM_WORDS  = 1 << (ADDR_W - 2);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        reuseMask = 1'b0;
  logic [4:0]  shiftAmt = '0;
  logic [4:0]  widthWords = '0;
  logic [5:0]  lineCount = '0;
  logic [2:0]  planeCount = '0;
  logic [ADDR_W-1:0] srcBase = '0, maskBase = '0, dstBase = '0;
  logic [ADDR_W-1:0] srcStride = '0, maskStride = '0, dstStride = '0;
  logic [ADDR_W-1:0] srcPlaneStride = '0, dstPlaneStride = '0;
  logic        memRd, memWr, done, err;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] mem    [0:MEM_WORDS-1];
  logic [31:0] expArr [0:MEM_WORDS-1];
  logic        fillReq = 1'b0;
  int          fillSeed = 0;

  logic        monClr = 1'b0;
  int          cyc = 0, nRd = 0, nWr = 0, nDone = 0, lastWrCyc = -1, doneCyc = -1;
  int          tKind [0:15];
  int          tAddr [0:15];
  int          tCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  masked_blit u0 (
    .clk(clk), .rstN(rstN), .start(start), .reuseMask(reuseMask),
    .shiftAmt(shiftAmt), .widthWords(widthWords), .lineCount(lineCount),
    .planeCount(planeCount), .srcBase(srcBase), .maskBase(maskBase),
    .dstBase(dstBase), .srcStride(srcStride), .maskStride(maskStride),
    .dstStride(dstStride), .srcPlaneStride(srcPlaneStride),
    .dstPlaneStride(dstPlaneStride), .memRd(memRd), .memWr(memWr),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .done(done), .err(err)
  );

  function automatic logic [31:0] pattern(input int idx, input int seed);
    logic [31:0] x;
    x = (32'(idx) * 32'h9E3779B1) ^ 32'(seed);
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    return x;
  endfunction

  // memory model: synchronous, one-cycle read latency
  always @(posedge clk) begin
    if (fillReq) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= pattern(i, fillSeed);
    end else begin
      if (memWr) mem[memAddr[ADDR_W-1:2]] <= memWdata;
      if (memRd) memRdata <= mem[memAddr[ADDR_W-1:2]];
    end
  end

  // access kinds: 0 mask read, 1 source read, 2 dest read, 3 dest write
  function automatic int kindOf(input logic [ADDR_W-1:0] a, input logic w);
    if (w) return 3;
    if (a < 12'h400) return 0;
    if (a < 12'h800) return 1;
    return 2;
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (monClr) begin
      nRd <= 0; nWr <= 0; nDone <= 0; lastWrCyc <= -1; doneCyc <= -1; tCnt <= 0;
    end else if (rstN) begin
      if (memRd) nRd <= nRd + 1;
      if (memWr) begin nWr <= nWr + 1; lastWrCyc <= cyc; end
      if (done) begin nDone <= nDone + 1; doneCyc <= cyc; end
      if ((memRd || memWr) && tCnt < 16) begin
        tKind[tCnt] <= kindOf(memAddr, memWr);
        tAddr[tCnt] <= int'(memAddr);
        tCnt <= tCnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic chkTrace(input int idx, input int kind, input int addr, input string req);
    chk(tKind[idx] == kind && tAddr[idx] == addr, req,
        $sformatf("trace[%0d] kind/addr", idx),
        (longint'(tKind[idx]) << 16) | tAddr[idx], (longint'(kind) << 16) | addr);
  endtask

  task automatic buildExp(input int seed, input int sb, input int mb, input int db,
                          input int sS, input int mS, input int dS, input int sP,
                          input int dP, input int w, input int l, input int p,
                          input int sh);
    logic [31:0] mr, sr, mc, sc;
    logic [63:0] t;
    int da;
    for (int i = 0; i < MEM_WORDS; i++) expArr[i] = pattern(i, seed);
    for (int pi = 0; pi < p; pi++) begin
      for (int li = 0; li < l; li++) begin
        mr = '0; sr = '0;
        for (int wi = 0; wi <= w; wi++) begin
          if (wi < w) begin
            t  = {pattern((mb + li*mS + 4*wi) / 4, seed), 32'b0} >> sh;
            mc = t[63:32] | mr; mr = t[31:0];
            t  = {pattern((sb + pi*sP + li*sS + 4*wi) / 4, seed), 32'b0} >> sh;
            sc = t[63:32] | sr; sr = t[31:0];
          end else begin
            mc = mr; sc = sr;
          end
          da = (db + pi*dP + li*dS + 4*wi) / 4;
          expArr[da] = (expArr[da] & ~mc) | sc;
        end
      end
    end
  endtask

  task automatic launch(input int seed, input int sb, input int mb, input int db,
                        input int sS, input int mS, input int dS, input int sP,
                        input int dP, input int w, input int l, input int p,
                        input int sh, input bit reuse);
    @(negedge clk);
    fillSeed = seed; fillReq = 1'b1; monClr = 1'b1;
    srcBase = sb[ADDR_W-1:0]; maskBase = mb[ADDR_W-1:0]; dstBase = db[ADDR_W-1:0];
    srcStride = sS[ADDR_W-1:0]; maskStride = mS[ADDR_W-1:0]; dstStride = dS[ADDR_W-1:0];
    srcPlaneStride = sP[ADDR_W-1:0]; dstPlaneStride = dP[ADDR_W-1:0];
    widthWords = w[4:0]; lineCount = l[5:0]; planeCount = p[2:0];
    shiftAmt = sh[4:0]; reuseMask = reuse;
    @(negedge clk);
    fillReq = 1'b0; monClr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 5000 && !done && !err; n++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic chkMem(input string req);
    int bad = 0, firstIdx = -1;
    for (int i = 0; i < MEM_WORDS; i++)
      if (mem[i] !== expArr[i]) begin
        bad++;
        if (firstIdx < 0) firstIdx = i;
      end
    if (firstIdx < 0) chk(1'b1, req, "memory image", 0, 0);
    else chk(1'b0, req, $sformatf("memory word %0d", firstIdx),
             mem[firstIdx], expArr[firstIdx]);
  endtask

  task automatic runGood(input string req, input int seed, input int sb, input int mb,
                         input int db, input int sS, input int mS, input int dS,
                         input int sP, input int dP, input int w, input int l,
                         input int p, input int sh, input bit reuse);
    int expRd, expWr;
    buildExp(seed, sb, mb, db, sS, mS, dS, sP, dP, w, l, p, sh);
    launch(seed, sb, mb, db, sS, mS, dS, sP, dP, w, l, p, sh, reuse);
    chkMem(req);
    expWr = p * l * (w + 1);
    expRd = reuse ? l * (1 + 3*p) : p * l * (3*w + 1);
    chk(nWr == expWr, "R4", "write count", nWr, expWr);
    chk(nRd == expRd, reuse ? "R7" : "R1", "read count", nRd, expRd);
    chk(nDone == 1 && doneCyc == lastWrCyc + 1, "R10", "done one cycle after last write",
        doneCyc, lastWrCyc + 1);
    chk(err == 1'b0, "R11", "err clear after valid start", err, 0);
  endtask

  // R3, R5: no shift, carries stay zero, trailing word unchanged
  task automatic testNoShift();
    runGood("R3", 11, 'h400, 'h000, 'h800, 8, 8, 12, 16, 24, 2, 2, 2, 0, 1'b0);
  endtask

  // R1, R2, R4, R6: shift 5 with full access trace
  task automatic testShiftTrace();
    runGood("R2", 22, 'h410, 'h020, 'h840, 8, 8, 12, 16, 24, 2, 2, 2, 5, 1'b0);
    chkTrace(0, 0, 'h020, "R1"); chkTrace(1, 1, 'h410, "R1");
    chkTrace(2, 2, 'h840, "R1"); chkTrace(3, 3, 'h840, "R1");
    chkTrace(4, 0, 'h024, "R6"); chkTrace(5, 1, 'h414, "R6");
    chkTrace(6, 2, 'h844, "R6"); chkTrace(7, 3, 'h844, "R6");
    chkTrace(8, 2, 'h848, "R4"); chkTrace(9, 3, 'h848, "R4");
    chkTrace(10, 0, 'h028, "R6"); chkTrace(11, 1, 'h418, "R6");
  endtask

  // R2, R6: maximum shift, three planes of three words
  task automatic testMaxShift();
    runGood("R2", 33, 'h500, 'h100, 'h900, 12, 12, 16, 48, 64, 3, 3, 3, 31, 1'b0);
  endtask

  // R5, R7: mask held across planes, rows outer
  task automatic testReuse();
    runGood("R5", 44, 'h600, 'h200, 'hA00, 8, 4, 8, 32, 32, 1, 3, 3, 12, 1'b1);
    chkTrace(0, 0, 'h200, "R7"); chkTrace(1, 1, 'h600, "R7");
    chkTrace(2, 2, 'hA00, "R7"); chkTrace(3, 3, 'hA00, "R7");
    chkTrace(4, 2, 'hA04, "R7"); chkTrace(5, 3, 'hA04, "R7");
    chkTrace(6, 1, 'h620, "R7"); chkTrace(7, 2, 'hA20, "R7");
  endtask

  task automatic testBad(input string req, input int sb, input int w, input bit reuse);
    for (int i = 0; i < MEM_WORDS; i++) expArr[i] = pattern(i, 55);
    launch(55, sb, 'h000, 'h800, 8, 8, 12, 16, 24, w, 2, 2, 3, reuse);
    chk(err == 1'b1, req, "err raised", err, 1);
    chk(nRd == 0 && nWr == 0, req, "no memory access", nRd + nWr, 0);
    chk(nDone == 0, req, "no done", nDone, 0);
    chkMem(req);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R11", "err sticky", err, 1);
  endtask

  // R10: empty job
  task automatic testEmpty();
    for (int i = 0; i < MEM_WORDS; i++) expArr[i] = pattern(i, 66);
    launch(66, 'h400, 'h000, 'h800, 8, 8, 12, 16, 24, 2, 0, 2, 4, 1'b0);
    chk(nDone == 1, "R10", "done on zero rows", nDone, 1);
    chk(nRd == 0 && nWr == 0, "R10", "no access on zero rows", nRd + nWr, 0);
    chkMem("R10");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && err == 1'b0 && memRd == 1'b0 && memWr == 1'b0, "R10",
        "reset outputs", {done, err, memRd, memWr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    testNoShift();
    testShiftTrace();
    testMaxShift();
    testReuse();
    testBad("R9", 'h402, 2, 1'b0);
    runGood("R11", 77, 'h440, 'h040, 'h8C0, 4, 4, 8, 8, 16, 1, 2, 1, 17, 1'b0);
    testBad("R8", 'h400, 2, 1'b1);
    testEmpty();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule